// File: doc/BRIEF.md
# Shared-Bus Chip-Select Address Decoder

This block sits between a processor's address bus and a set of memory-mapped devices that share one data bus. Each device owns a region of the address space. A parameter fixes the region's base address, and a second parameter fixes its size as a power of two, 2^k. The decoder compares the upper address bits of each region against the base. It drives one active-low chip select, or none when no region is addressed. It passes the low k bits to the chosen device as that device's local address.

Reads return the selected device's data, so the output behaves like a shared bus with tristate drivers. When no device is selected, the read data is a fixed idle value, which models a bus that nothing drives. A registered configuration-error flag reports a region map that cannot be decoded cleanly. A region is bad if its base is not aligned to its size or if it overlaps another region. Even with a bad map, the select outputs stay mutually exclusive.

Top module: `chip_select_decoder`

## Requirements
- R1: When the address falls in no region, every bit of `cs_n` is 1.
- R2: At no time is more than one bit of `cs_n` at 0.
- R3: `cs_n[i]` is 0 exactly when the top ADDR_W−k_i address bits equal those bits of region i's base and no lower-numbered region also matches. Here k_i is region i's size exponent, and region 0 has the highest priority.
- R4: The ADDR_W-bit slice i of `dev_addr` (bits i*ADDR_W upward) holds the low k_i address bits, zero-extended, while `cs_n[i]` is 0. At all other times the slice is all zeros.
- R5: While device i is selected, `rd_data` equals slice i of `dev_rdata` (bits i*DATA_W upward).
- R6: While no device is selected, `rd_data` equals the parameter IDLE_DATA.
- R7: `cfg_err` is 0 while `rst_n` is low. From the first clock edge after reset is released, it is 1 if any region's base has a nonzero bit below bit k_i or if k_i exceeds ADDR_W. It stays 0 for a legal map.
- R8: `cfg_err` is also 1 after that edge if two regions share any address. In the shared range, only the lower-numbered region is selected.
- R9: In a 16-bit space, a 2^8 region based at 0xFF00 covers 0xFF00 to 0xFFFF, and 0xFEFF is outside it. In a 28-bit space, a 2^24 region based at 0x3000000 maps address 0x35E3C03 to local address 0x5E3C03 and ends at 0x3FFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration-error register |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Full processor address |
| dev_rdata | input | NUM_DEV*DATA_W | Read data of each device, device i in slice i |
| cs_n | output | NUM_DEV | Active-low chip select per device |
| dev_addr | output | NUM_DEV*ADDR_W | Local address per device, zero when not selected |
| rd_data | output | DATA_W | Read data from the selected device, or IDLE_DATA |
| cfg_err | output | 1 | Registered flag for an unaligned or overlapping map |

## Verification
The hardest condition to reach is the behaviour of a broken map. With a legal map, the overlap priority and the error flag can never be observed at the ports. The bench therefore builds extra instances alongside the main one: one with an unaligned base, one with two nested regions, and one in a 28-bit space. It probes the shared range of the nested pair to confirm that only the lower-numbered region is selected. Every address of the 16-bit default map is also swept, so each region edge and each gap is covered.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    typedef struct packed {
        logic err;
    } cfg_state_t;

    function automatic logic [63:0] low_mask(input int k);
        logic [63:0] m;
        for (int i = 0; i < 64; i++) begin
            m[i] = (i < k);
        end
        return m;
    endfunction

    function automatic logic region_bad(input logic [63:0] base, input int k, input int aw);
        return (k > aw) || ((base & low_mask(k)) != 64'd0);
    endfunction

    function automatic logic regions_overlap(input logic [63:0] b0, input int k0,
                                             input logic [63:0] b1, input int k1);
        int kmax;
        kmax = (k0 > k1) ? k0 : k1;
        return ((b0 ^ b1) & ~low_mask(kmax)) == 64'd0;
    endfunction

endpackage

// File: rtl/region_match.sv
module region_match
    import addr_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter int K = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] local_addr
);
    localparam logic [63:0] MASK64 = low_mask(K);
    localparam logic [ADDR_W-1:0] LOW_MASK = MASK64[ADDR_W-1:0];

    always_comb begin
        hit        = ((addr ^ BASE) & ~LOW_MASK) == '0;
        local_addr = addr & LOW_MASK;
    end
endmodule

// File: rtl/cfg_check.sv
module cfg_check
    import addr_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NUM_DEV = 4,
    parameter logic [NUM_DEV*ADDR_W-1:0] BASE_LIST = '0,
    parameter logic [NUM_DEV*8-1:0] SIZE_LIST = '0
) (
    input  logic clk,
    input  logic rst_n,
    output logic cfg_err
);
    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.err = 1'b0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (region_bad(64'(BASE_LIST[i*ADDR_W +: ADDR_W]), int'(SIZE_LIST[i*8 +: 8]), ADDR_W)) begin
                state_d.err = 1'b1;
            end
            for (int j = i + 1; j < NUM_DEV; j++) begin
                if (regions_overlap(64'(BASE_LIST[i*ADDR_W +: ADDR_W]), int'(SIZE_LIST[i*8 +: 8]),
                                    64'(BASE_LIST[j*ADDR_W +: ADDR_W]), int'(SIZE_LIST[j*8 +: 8]))) begin
                    state_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg_err = state_q.err;

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

// File: rtl/read_mux.sv
module read_mux #(
    parameter int NUM_DEV = 4,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] IDLE_DATA = '1
) (
    input  logic [NUM_DEV-1:0]        sel,
    input  logic [NUM_DEV*DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0]         rd_data
);
    always_comb begin
        rd_data = IDLE_DATA;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (sel[i]) begin
                rd_data = dev_rdata[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
    import addr_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NUM_DEV = 4,
    parameter int DATA_W = 8,
    parameter logic [NUM_DEV*ADDR_W-1:0] BASE_LIST = {16'h8000, 16'hFF00, 16'h7000, 16'h0000},
    parameter logic [NUM_DEV*8-1:0] SIZE_LIST = {8'd13, 8'd8, 8'd12, 8'd14},
    parameter logic [DATA_W-1:0] IDLE_DATA = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_DEV*DATA_W-1:0] dev_rdata,
    output logic [NUM_DEV-1:0]        cs_n,
    output logic [NUM_DEV*ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      cfg_err
);
    logic [NUM_DEV-1:0]        hit;
    logic [NUM_DEV-1:0]        sel;
    logic [NUM_DEV*ADDR_W-1:0] local_all;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_region
        region_match #(
            .ADDR_W(ADDR_W),
            .BASE  (BASE_LIST[g*ADDR_W +: ADDR_W]),
            .K     (int'(SIZE_LIST[g*8 +: 8]))
        ) u_match (
            .addr      (addr),
            .hit       (hit[g]),
            .local_addr(local_all[g*ADDR_W +: ADDR_W])
        );

        assign dev_addr[g*ADDR_W +: ADDR_W] = sel[g] ? local_all[g*ADDR_W +: ADDR_W] : '0;

        // R3
        sel_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cs_n[g] |-> hit[g]);
    end

    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < NUM_DEV; i++) begin
            sel[i] = hit[i] && !taken;
            taken  = taken || hit[i];
        end
    end

    assign cs_n = ~sel;

    read_mux #(
        .NUM_DEV  (NUM_DEV),
        .DATA_W   (DATA_W),
        .IDLE_DATA(IDLE_DATA)
    ) u_mux (
        .sel      (sel),
        .dev_rdata(dev_rdata),
        .rd_data  (rd_data)
    );

    cfg_check #(
        .ADDR_W   (ADDR_W),
        .NUM_DEV  (NUM_DEV),
        .BASE_LIST(BASE_LIST),
        .SIZE_LIST(SIZE_LIST)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_err(cfg_err)
    );

    // R2
    cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R6
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> (rd_data == IDLE_DATA));
endmodule

// File: tb/sim_chip_select_decoder.sv
module sim_chip_select_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // default map instance
    logic [15:0] a0;
    logic [31:0] rd0 = {8'h96, 8'hC3, 8'h5A, 8'h3C};
    logic [3:0]  cs0;
    logic [63:0] da0;
    logic [7:0]  rdo0;
    logic        err0;
    chip_select_decoder u0 (.clk(clk), .rst_n(rst_n), .addr(a0), .dev_rdata(rd0),
        .cs_n(cs0), .dev_addr(da0), .rd_data(rdo0), .cfg_err(err0));

    // unaligned base
    logic [7:0]  a1 = '0;
    logic [1:0]  cs1;
    logic [15:0] da1;
    logic [7:0]  rdo1;
    logic        err1;
    chip_select_decoder #(.ADDR_W(8), .NUM_DEV(2), .BASE_LIST(16'h2400), .SIZE_LIST(16'h0404))
        u1 (.clk(clk), .rst_n(rst_n), .addr(a1), .dev_rdata(16'h2211),
        .cs_n(cs1), .dev_addr(da1), .rd_data(rdo1), .cfg_err(err1));

    // nested regions
    logic [7:0]  a2 = '0;
    logic [1:0]  cs2;
    logic [15:0] da2;
    logic [7:0]  rdo2;
    logic        err2;
    chip_select_decoder #(.ADDR_W(8), .NUM_DEV(2), .BASE_LIST(16'h4000), .SIZE_LIST(16'h0607))
        u2 (.clk(clk), .rst_n(rst_n), .addr(a2), .dev_rdata(16'hBBAA),
        .cs_n(cs2), .dev_addr(da2), .rd_data(rdo2), .cfg_err(err2));

    // 28-bit space
    logic [27:0] a3 = '0;
    logic [0:0]  cs3;
    logic [27:0] da3;
    logic [7:0]  rdo3;
    logic        err3;
    chip_select_decoder #(.ADDR_W(28), .NUM_DEV(1), .BASE_LIST(28'h3000000), .SIZE_LIST(8'd24))
        u3 (.clk(clk), .rst_n(rst_n), .addr(a3), .dev_rdata(8'h77),
        .cs_n(cs3), .dev_addr(da3), .rd_data(rdo3), .cfg_err(err3));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    int bases[4] = '{16'h0000, 16'h7000, 16'hFF00, 16'h8000};
    int ks[4]    = '{14, 12, 8, 13};

    initial begin
        a0 = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 reset", {63'd0, err0}, 64'd0);
        chk("R7 reset", {63'd0, err1}, 64'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R7 legal map", {63'd0, err0}, 64'd0);
        chk("R7 unaligned", {63'd0, err1}, 64'd1);
        chk("R8 overlap", {63'd0, err2}, 64'd1);
        chk("R7 legal 28-bit", {63'd0, err3}, 64'd0);

        for (int a = 0; a < 65536; a++) begin
            logic [3:0]  ecs;
            logic [63:0] eda;
            logic [7:0]  erd;
            bit taken;
            a0 = 16'(a);
            ecs = 4'hF; eda = '0; erd = 8'hFF; taken = 0;
            for (int d = 0; d < 4; d++) begin
                if (!taken && ((a ^ bases[d]) >> ks[d]) == 0) begin
                    taken = 1;
                    ecs[d] = 1'b0;
                    eda[d*16 +: 16] = 16'(a & ((1 << ks[d]) - 1));
                    erd = rd0[d*8 +: 8];
                end
            end
            #1;
            chk(taken ? "R3 select" : "R1 idle", {60'd0, cs0}, {60'd0, ecs});
            chk("R2 exclusive", {63'd0, ($countones(~cs0) <= 1)}, 64'd1);
            chk("R4 local addr", da0, eda);
            chk(taken ? "R5 read data" : "R6 idle data", {56'd0, rdo0}, {56'd0, erd});
            @(negedge clk);
        end

        a0 = 16'hFF00; #1 chk("R9 region low edge", {60'd0, cs0}, 64'hB);
        a0 = 16'hFFFF; #1 chk("R9 region high edge", {60'd0, cs0}, 64'hB);
        a0 = 16'hFEFF; #1 chk("R9 below region", {60'd0, cs0}, 64'hF);

        a2 = 8'h50; #1;
        chk("R8 priority cs", {62'd0, cs2}, 64'h2);
        chk("R8 priority data", {56'd0, rdo2}, 64'hAA);
        chk("R8 priority addr", {48'd0, da2}, 64'h0050);
        a2 = 8'h90; #1 chk("R1 idle nested", {62'd0, cs2}, 64'h3);

        a3 = 28'h35E3C03; #1;
        chk("R9 28-bit select", {63'd0, cs3}, 64'd0);
        chk("R9 28-bit local", {36'd0, da3}, 64'h5E3C03);
        a3 = 28'h3FFFFFF; #1 chk("R9 28-bit top", {36'd0, da3}, 64'hFFFFFF);
        a3 = 28'h4000000; #1 chk("R1 28-bit above", {63'd0, cs3}, 64'd1);
        a3 = 28'h2FFFFFF; #1 chk("R4 28-bit idle addr", {36'd0, da3}, 64'd0);

        @(negedge clk);
        chk("R7 flag holds", {63'd0, err0}, 64'd0);
        chk("R8 flag holds", {63'd0, err2}, 64'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule